// File: doc/BRIEF.md
# Double-Buffered Dual-Modulus Feedback Divider

This block is the feedback divider of a digital phase-locked loop. It is clocked by the output of an external two-modulus prescaler, one clock per prescaler cycle. A main counter runs M prescaler cycles per divider period, and a swallow counter holds the modulus-control output high for the first A of those cycles. The prescaler therefore divides by its larger modulus A times and by its smaller modulus M−A times, and the overall ratio is P·M + A. One pulse per period goes to the phase detector. A select output tells the prescaler which modulus pair to use: the 8/9 pair, or the other pair.

Divider settings are kept in two storage slots. One slot drives the counters while the other is written over a three-wire serial port. Flipping the select input hands control to the other slot, and any change always takes effect at a period boundary, so the loop never sees a truncated or stretched period. A guard copies slot data into the working register only while more than GUARD prescaler cycles remain in the current period. A request that arrives later waits for the next period. A short serial word changes only the swallow value, at the end of the current period. It leaves M and the modulus choice alone, which allows quick hops to an adjacent channel.

The serial port, the edge detectors on the select line and the outputs all share the prescaler-rate clock. The serial inputs are sampled in that domain, so each serial clock level must last at least one clock.

Top module: `dmod_fb_divider`

## Requirements
- R1: After reset both slots, the working register and the counters hold M=16, A=0 and the 9/10-class (non-8/9) modulus: `fb_pulse` repeats every 16 clocks, and `mod_ctl` and `small_mod_sel` are 0.
- R2: `fb_pulse` is high for exactly one clock in every M clocks, where M is the 8-bit value taken from the slot in control. M must be at least 4.
- R3: Within each period, `mod_ctl` is high for the first min(A, M) clocks after the pulse clock and low for the rest, where A is the effective swallow value.
- R4: `small_mod_sel` equals the modulus bit of the governing setting and changes only at a period boundary. When it is 1, bit 3 of A is ignored and the effective A is A mod 8.
- R5: A full word is 16 bits, shifted MSB first on rising `ser_clk` while `ser_en` is high, and decoded when `ser_en` falls. From first to last the bits are: code 2'b00, target slot (0 or 1), modulus bit, M[7:0], A[3:0].
- R6: A full word aimed at the slot not in control leaves the output pattern unchanged.
- R7: A change of `buf_sel` hands control to the slot it names (0 or 1). Every measured period has either the old length or the new length, never a mixture.
- R8: Count the pulse clock as 1 and count back to the clock in which a new `buf_sel` level is first applied. If that count is 5 or more, the new slot governs the very next period. If it is 4 or less, one more old period runs first.
- R9: A 6-bit word (code 2'b01, then A[3:0]) changes only A. The period in progress keeps its old A, the next period uses the new A, and M and the modulus bit stay as they were.
- R10: A word of any other bit count, or with code 2'b10 or 2'b11, changes nothing at the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Prescaler output clock, one edge per prescaler cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial clock; data is captured on its rising level change |
| ser_en | input | 1 | Serial frame enable; its falling edge decodes the word |
| ser_dat | input | 1 | Serial data, MSB first |
| buf_sel | input | 1 | Selects the slot in control (0 or 1) |
| mod_ctl | output | 1 | Modulus control to prescaler; 1 selects the larger modulus |
| small_mod_sel | output | 1 | 1 selects the 8/9 prescaler pair |
| fb_pulse | output | 1 | One-clock pulse at the end of each divider period |

## Verification
A wrong count or a wrong slot shows as a wrong distance between successive `fb_pulse` clocks, or as a wrong count of `mod_ctl`-high clocks. This becomes visible within one or two periods of the change that caused it. A guard off by one shifts the first new-length period by a whole period, so the bench places `buf_sel` changes exactly 4 and 5 clocks before a pulse. A swallow update applied early or late shows up in the `mod_ctl` count of the period during which the short word arrived.

// File: rtl/fbd_pkg.sv
package fbd_pkg;

  localparam int FBD_M_W   = 8;
  localparam int FBD_A_W   = 4;
  localparam int FBD_CTL_W = 2;
  localparam int FBD_NBUF  = 2;

  localparam int FBD_FULL_LEN  = FBD_CTL_W + 2 + FBD_M_W + FBD_A_W;
  localparam int FBD_AONLY_LEN = FBD_CTL_W + FBD_A_W;

  localparam logic [FBD_CTL_W-1:0] FBD_CODE_FULL  = 2'b00;
  localparam logic [FBD_CTL_W-1:0] FBD_CODE_AONLY = 2'b01;

  typedef struct packed {
    logic                 mode89;
    logic [FBD_M_W-1:0]   m;
    logic [FBD_A_W-1:0]   a;
  } fbd_word_t;

  // Swallow value actually used: top bit dropped in 8/9 mode.
  function automatic logic [FBD_A_W-1:0] fbd_eff_a(input fbd_word_t w);
    logic [FBD_A_W-1:0] r;
    r = w.a;
    if (w.mode89) r[FBD_A_W-1] = 1'b0;
    return r;
  endfunction

  // A slot may be copied only while enough of the period remains.
  function automatic logic fbd_guard_ok(input logic [FBD_M_W-1:0] rem,
                                        input int guard);
    return int'(rem) > guard;
  endfunction

endpackage

// File: rtl/fbd_serial_rx.sv
module fbd_serial_rx
  import fbd_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sclk,
  input  logic                sen,
  input  logic                sdat,
  output logic                full_stb,
  output logic                full_tgt,
  output fbd_word_t           full_word,
  output logic                aonly_stb,
  output logic [FBD_A_W-1:0]  aonly_val
);

  localparam int CNT_W = $clog2(FBD_FULL_LEN + 2);
  localparam logic [CNT_W-1:0] CNT_MAX   = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] LEN_FULL  = CNT_W'(FBD_FULL_LEN);
  localparam logic [CNT_W-1:0] LEN_AONLY = CNT_W'(FBD_AONLY_LEN);
  localparam int WORD_W = $bits(fbd_word_t);

  logic                    sclk_q, sen_q;
  logic [FBD_FULL_LEN-1:0] sr;
  logic [CNT_W-1:0]        cnt;

  logic sclk_rise, sen_fall;
  assign sclk_rise = sclk & ~sclk_q;
  assign sen_fall  = sen_q & ~sen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      sen_q  <= 1'b0;
      sr     <= '0;
      cnt    <= '0;
    end else begin
      sclk_q <= sclk;
      sen_q  <= sen;
      if (!sen) begin
        cnt <= '0;
      end else if (sclk_rise) begin
        sr <= {sr[FBD_FULL_LEN-2:0], sdat};
        if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
      end
    end
  end

  // Decode happens in the cycle the enable falls, from registered bits.
  assign full_stb  = sen_fall && (cnt == LEN_FULL) &&
                     (sr[FBD_FULL_LEN-1 -: FBD_CTL_W] == FBD_CODE_FULL);
  assign full_tgt  = sr[WORD_W];
  assign full_word = fbd_word_t'(sr[WORD_W-1:0]);

  assign aonly_stb = sen_fall && (cnt == LEN_AONLY) &&
                     (sr[FBD_AONLY_LEN-1 -: FBD_CTL_W] == FBD_CODE_AONLY);
  assign aonly_val = sr[FBD_A_W-1:0];

endmodule

// File: rtl/fbd_buf_bank.sv
module fbd_buf_bank
  import fbd_pkg::*;
#(
  parameter int        GUARD    = 3,
  parameter fbd_word_t RST_WORD = '0
)(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sel,
  input  logic                full_stb,
  input  logic                full_tgt,
  input  fbd_word_t           full_word,
  input  logic                aonly_stb,
  input  logic [FBD_A_W-1:0]  aonly_val,
  input  logic [FBD_M_W-1:0]  rem,
  input  logic                reload,
  output fbd_word_t           load_word
);

  logic               sel_q;
  logic               pend;
  logic               a_pend;
  logic [FBD_A_W-1:0] a_new;
  fbd_word_t          work;

  // Named internal events
  logic sel_tog, xfer, a_apply;
  assign sel_tog = sel ^ sel_q;
  assign xfer    = pend && fbd_guard_ok(rem, GUARD);
  assign a_apply = a_pend && reload;

  for (genvar gb = 0; gb < FBD_NBUF; gb++) begin : g_buf
    fbd_word_t q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q <= RST_WORD;
      end else if (full_stb && (int'(full_tgt) == gb)) begin
        q <= full_word;
      end else if (aonly_stb && (int'(sel_q) == gb)) begin
        q.a <= aonly_val;
      end
    end
  end

  fbd_word_t active_buf;
  assign active_buf = sel_q ? g_buf[1].q : g_buf[0].q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= 1'b0;
      pend   <= 1'b0;
      a_pend <= 1'b0;
      a_new  <= '0;
      work   <= RST_WORD;
    end else begin
      sel_q  <= sel;
      pend   <= (pend & ~xfer) | full_stb | sel_tog;
      a_pend <= (a_pend & ~a_apply) | aonly_stb;
      if (aonly_stb) a_new <= aonly_val;
      if (xfer)         work   <= active_buf;
      else if (a_apply) work.a <= a_new;
    end
  end

  always_comb begin
    load_word = work;
    if (a_pend) load_word.a = a_new;
  end

  // R8: the working M and modulus change only after a cycle with room left
  a_r8_guarded_copy: assert property (@(posedge clk) disable iff (!rst_n)
    ($changed(work.m) || $changed(work.mode89)) |-> ($past(rem) > GUARD));

  // R9: a swallow-only update never touches M or the modulus bit
  a_r9_aonly_keeps_m: assert property (@(posedge clk) disable iff (!rst_n)
    a_apply |=> ($stable(work.m) && $stable(work.mode89)));

endmodule

// File: rtl/fbd_counters.sv
module fbd_counters
  import fbd_pkg::*;
#(
  parameter fbd_word_t RST_WORD = '0
)(
  input  logic                clk,
  input  logic                rst_n,
  input  fbd_word_t           load_word,
  output logic [FBD_M_W-1:0]  rem,
  output logic                reload,
  output logic                mc,
  output logic                mode89
);

  logic [FBD_M_W-1:0] mcnt;
  logic [FBD_A_W-1:0] acnt;
  logic               run_mode;

  assign rem    = mcnt;
  assign reload = (mcnt == FBD_M_W'(1));
  assign mc     = (acnt != '0);
  assign mode89 = run_mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mcnt     <= RST_WORD.m;
      acnt     <= fbd_eff_a(RST_WORD);
      run_mode <= RST_WORD.mode89;
    end else if (reload) begin
      mcnt     <= load_word.m;
      acnt     <= fbd_eff_a(load_word);
      run_mode <= load_word.mode89;
    end else begin
      mcnt <= mcnt - 1'b1;
      if (acnt != '0) acnt <= acnt - 1'b1;
    end
  end

  // R2: each new period starts with the full governing M
  a_r2_reload_takes_m: assert property (@(posedge clk) disable iff (!rst_n)
    reload |=> (rem == $past(load_word.m)));

  // R3: modulus control can only start at a period boundary
  a_r3_mc_rises_at_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mc) |-> $past(reload));

  // R4: in 8/9 mode the swallow count never uses its top bit
  a_r4_small_mod_a_fits: assert property (@(posedge clk) disable iff (!rst_n)
    mode89 |-> !acnt[FBD_A_W-1]);

  // R4: modulus choice changes only at a boundary
  a_r4_mode_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    $changed(mode89) |-> $past(reload));

endmodule

// File: rtl/dmod_fb_divider.sv
module dmod_fb_divider
  import fbd_pkg::*;
#(
  parameter int                 GUARD    = 3,
  parameter logic [FBD_M_W-1:0] RST_M    = 8'd16,
  parameter logic [FBD_A_W-1:0] RST_A    = 4'd0,
  parameter logic               RST_MODE = 1'b0
)(
  input  logic clk,
  input  logic rst_n,
  input  logic ser_clk,
  input  logic ser_en,
  input  logic ser_dat,
  input  logic buf_sel,
  output logic mod_ctl,
  output logic small_mod_sel,
  output logic fb_pulse
);

  localparam fbd_word_t RST_WORD = '{mode89: RST_MODE, m: RST_M, a: RST_A};

  logic               full_stb, full_tgt, aonly_stb;
  fbd_word_t          full_word, load_word;
  logic [FBD_A_W-1:0] aonly_val;
  logic [FBD_M_W-1:0] rem;
  logic               reload;

  fbd_serial_rx u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .sclk      (ser_clk),
    .sen       (ser_en),
    .sdat      (ser_dat),
    .full_stb  (full_stb),
    .full_tgt  (full_tgt),
    .full_word (full_word),
    .aonly_stb (aonly_stb),
    .aonly_val (aonly_val)
  );

  fbd_buf_bank #(.GUARD(GUARD), .RST_WORD(RST_WORD)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel       (buf_sel),
    .full_stb  (full_stb),
    .full_tgt  (full_tgt),
    .full_word (full_word),
    .aonly_stb (aonly_stb),
    .aonly_val (aonly_val),
    .rem       (rem),
    .reload    (reload),
    .load_word (load_word)
  );

  fbd_counters #(.RST_WORD(RST_WORD)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_word (load_word),
    .rem       (rem),
    .reload    (reload),
    .mc        (mod_ctl),
    .mode89    (small_mod_sel)
  );

  assign fb_pulse = reload;

endmodule

// File: tb/tb_dmod_fb_divider.sv
module tb_dmod_fb_divider;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_clk = 1'b0, ser_en = 1'b0, ser_dat = 1'b0, buf_sel = 1'b0;
  logic mod_ctl, small_mod_sel, fb_pulse;

  int vecs = 0;
  int errs = 0;

  always #5 clk = ~clk;

  dmod_fb_divider dut (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_en(ser_en),
    .ser_dat(ser_dat), .buf_sel(buf_sel), .mod_ctl(mod_ctl),
    .small_mod_sel(small_mod_sel), .fb_pulse(fb_pulse)
  );

  task automatic check(input string req, input int act, input int exp);
    vecs++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send(input logic [31:0] bits, input int len);
    @(negedge clk);
    ser_en = 1'b1;
    for (int i = 0; i < len; i++) begin
      ser_dat = bits[len-1-i];
      @(negedge clk); ser_clk = 1'b1;
      @(negedge clk); ser_clk = 1'b0;
    end
    @(negedge clk); ser_en = 1'b0;
    @(negedge clk);
  endtask

  function automatic logic [31:0] full_frame(input int tgt, input int md,
                                             input int m, input int a);
    return 32'({2'b00, tgt[0], md[0], m[7:0], a[3:0]});
  endfunction

  // Advance to the next negedge with fb_pulse high.
  task automatic sync_pulse();
    int lim = 0;
    @(negedge clk);
    while (!fb_pulse && lim < 2000) begin @(negedge clk); lim++; end
  endtask

  // Starting at a pulse negedge, count clocks and mod_ctl-high clocks to the next pulse.
  task automatic count_period(output int n, output int ahi);
    n = 0; ahi = 0;
    do begin
      @(negedge clk);
      n++;
      if (mod_ctl) ahi++;
    end while (!fb_pulse && n < 2000);
  endtask

  function automatic int exp_a(input int md, input int a, input int m);
    int e = md ? (a % 8) : a;
    return (e < m) ? e : m;
  endfunction

  task automatic prog_check(input string req, input int md, input int m, input int a);
    int n, ahi;
    send(full_frame(0, md, m, a), 16);
    sync_pulse(); sync_pulse();
    count_period(n, ahi);
    check(req, n, m);
    check(req, ahi, exp_a(md, a, m));
    check(req, int'(small_mod_sel), md);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errs++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    int n, ahi, n2, ahi2;
    int ms [5];
    ms = '{4, 5, 9, 17, 33};

    repeat (4) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R1: reset state
    check("R1 mod_ctl", int'(mod_ctl), 0);
    check("R1 small_mod_sel", int'(small_mod_sel), 0);
    sync_pulse();
    count_period(n, ahi);
    check("R1 period", n, 16);
    check("R1 swallow", ahi, 0);

    // R2 R3 R4 R5: sweep M, A and the modulus bit
    for (int md = 0; md < 2; md++)
      for (int mi = 0; mi < 5; mi++)
        for (int a = 0; a < 16; a++)
          if ((md ? a % 8 : a) <= ms[mi])
            prog_check(md ? "R4 R5 sweep" : "R2 R3 R5 sweep", md, ms[mi], a);

    // R6: write to the idle slot leaves outputs alone
    prog_check("R6 base", 0, 20, 3);
    send(full_frame(1, 1, 12, 7), 16);
    sync_pulse();
    count_period(n, ahi);
    count_period(n2, ahi2);
    check("R6 period", n, 20);   check("R6 swallow", ahi, 3);
    check("R6 period2", n2, 20); check("R6 swallow2", ahi2, 3);
    check("R6 mode", int'(small_mod_sel), 0);

    // R7 R8: select change 5 clocks before the pulse -> next period
    prog_check("R8 base", 0, 10, 2);
    sync_pulse();
    repeat (6) @(negedge clk);
    buf_sel = 1'b1;
    sync_pulse();
    count_period(n, ahi);
    check("R8 r5 period", n, 12);
    check("R8 r5 swallow", ahi, 7);
    check("R7 mode follows slot", int'(small_mod_sel), 1);

    // R7 R8: select change 4 clocks before the pulse -> one more old period
    sync_pulse();
    repeat (9) @(negedge clk);
    buf_sel = 1'b0;
    sync_pulse();
    count_period(n, ahi);
    count_period(n2, ahi2);
    check("R8 r4 old period", n, 12);
    check("R8 r4 old swallow", ahi, 7);
    check("R7 new period", n2, 10);
    check("R7 new swallow", ahi2, 2);
    check("R7 mode back", int'(small_mod_sel), 0);

    // R9: swallow-only word during a period
    prog_check("R9 base", 0, 40, 5);
    sync_pulse();
    fork
      count_period(n, ahi);
      begin repeat (2) @(negedge clk); send(32'({2'b01, 4'd9}), 6); end
    join
    count_period(n2, ahi2);
    check("R9 current period kept", ahi, 5);
    check("R9 current length", n, 40);
    check("R9 new swallow", ahi2, 9);
    check("R9 M kept", n2, 40);
    check("R9 mode kept", int'(small_mod_sel), 0);

    // R9 R4: swallow-only word in 8/9 mode drops bit 3
    prog_check("R9 base89", 1, 40, 3);
    send(32'({2'b01, 4'd14}), 6);
    sync_pulse(); sync_pulse();
    count_period(n, ahi);
    check("R9 R4 masked swallow", ahi, 6);
    check("R9 M kept 89", n, 40);
    check("R9 mode kept 89", int'(small_mod_sel), 1);

    // R10: malformed words ignored
    prog_check("R10 base", 0, 30, 4);
    send(full_frame(0, 1, 7, 1) >> 1, 15);
    send(32'({2'b10, 4'd2}), 6);
    send(32'({2'b11, 1'b0, 1'b1, 8'd7, 4'd1}), 16);
    send(32'({full_frame(0, 1, 7, 1), 1'b0}), 17);
    sync_pulse(); sync_pulse();
    count_period(n, ahi);
    check("R10 period", n, 30);
    check("R10 swallow", ahi, 4);
    check("R10 mode", int'(small_mod_sel), 0);

    $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

endmodule